// File: doc/BRIEF.md
# RTC Register Pointer and Snapshot Front End

This block sits between a byte-level 2-wire slave engine and the register file of a real-time clock. The slave engine reports decoded bus events to it: a start, a stop, a pointer load, a finished byte read, a received write byte and the acknowledge of that byte. The block keeps the register address pointer and presents the read byte for the current address. It also passes each written byte on to the live register side.

The address space has ten byte registers. Addresses 00h to 06h are timekeeping counters, 07h is the control register, and 08h and 09h are auxiliary registers. The pointer steps through two separate wrap regions. Stepping from 07h goes back to 00h, so the auxiliary bytes can only be reached by loading the pointer with 08h or 09h. Stepping from 09h also goes back to 00h.

Reads of the timekeeping bytes come from a snapshot copy of the live counters rather than from the counters themselves. The snapshot is refreshed on every start, on every stop, and whenever the pointer steps onto 00h. A multibyte time read therefore sees one coherent instant while the live clock keeps counting. Writes are held in a staging byte and handed to the live side at the acknowledge. A write to the seconds byte also pulses a reset to the sub-second divider.

The event inputs are single-cycle strobes with no back-pressure. The slave engine paces the bytes, and the block takes every strobe in the cycle it is presented.

Top module: `rtc_regfront`

## Requirements
- R1: While `rst_n` is low and after it is released, the pointer is 00h, the snapshot equals `live_regs` bytes 0–6 (so `rd_data` shows live byte 0), and `commit_valid` and `div_rst` are 0.
- R2: A `rd_done` or `wr_ack` strobe without `ptr_load` moves the pointer to the next address when it is at 00h–06h or at 08h. The new pointer is visible from the next cycle. With no strobe, the pointer holds.
- R3: Stepping from address 07h (control) moves the pointer to 00h, not to 08h.
- R4: Stepping from address 09h moves the pointer to 00h.
- R5: `ptr_load` sets the pointer to `ptr_load_val` when that value is 09h or below, and to 00h when it is above 09h. A load takes priority over a step strobed in the same cycle.
- R6: The snapshot takes a copy of `live_regs` bytes 0–6 at the clock edge of a `ev_start`, an `ev_stop`, or a step that lands on 00h. At all other times it holds, so changes on `live_regs` do not show through on reads of 00h–06h.
- R7: `rd_data` is snapshot byte N when the pointer N is 00h–06h, and `live_regs[8N+7:8N]` when N is 07h–09h. It follows the current pointer in the same cycle.
- R8: `wr_byte` latches `wr_data` into the staging byte. On the edge where `wr_ack` is sampled, `commit_valid` goes high for exactly the following cycle. In that cycle `commit_addr` is the pointer at the acknowledge and `commit_data` is the staged byte (or `wr_data` if `wr_byte` is strobed in the same cycle).
- R9: `div_rst` is high together with `commit_valid` exactly when `commit_addr` is 00h (seconds), and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | Bus start seen (strobe) |
| ev_stop | input | 1 | Bus stop seen (strobe) |
| ptr_load | input | 1 | Pointer load strobe |
| ptr_load_val | input | 8 | Address byte sent by the host |
| rd_done | input | 1 | A read byte was finished (strobe) |
| wr_byte | input | 1 | A write data byte was received (strobe) |
| wr_data | input | 8 | Received write byte |
| wr_ack | input | 1 | Acknowledge of the received write byte (strobe) |
| live_regs | input | 80 | Live register bytes, byte N at bits 8N+7:8N |
| rd_data | output | 8 | Byte at the current pointer |
| commit_valid | output | 1 | One-cycle write commit to the live side |
| commit_addr | output | 4 | Address of the committed byte |
| commit_data | output | 8 | Committed byte |
| div_rst | output | 1 | Sub-second divider reset pulse |

## Verification
Every strobe is applied for one cycle and sampled by one clock edge. After that edge:
- The pointer, the snapshot and the commit outputs are all due in the next cycle.
- `rd_data` is a combinational view of the pointer, so it is due in that same next cycle.

The bench therefore drives inputs on the falling edge, lets exactly one rising edge pass, and checks on the following falling edge. For `commit_valid`, it checks one more cycle later to confirm that the pulse is a single cycle long. The live register values are changed between events. This separates snapshot data from live data: a stale or refreshed byte shows up on `rd_data` with a value that differs from the live bytes.

// File: rtl/rtc_front_pkg.sv
package rtc_front_pkg;
  localparam int RTC_DW     = 8;   // register byte width
  localparam int RTC_N_TIME = 7;   // timekeeping bytes 0..N_TIME-1
  localparam int RTC_N_REGS = 10;  // total register count
  localparam int RTC_AW     = 8;   // width of the host address byte
endpackage

// File: rtl/rtc_ptr.sv
module rtc_ptr #(
  parameter int N_TIME = rtc_front_pkg::RTC_N_TIME,
  parameter int N_REGS = rtc_front_pkg::RTC_N_REGS,
  parameter int AW     = rtc_front_pkg::RTC_AW,
  parameter int PW     = $clog2(N_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic          wrap_now
);
  localparam logic [PW-1:0] END_T = PW'(N_TIME);      // control address
  localparam logic [PW-1:0] LAST  = PW'(N_REGS - 1);  // last aux address

  logic          at_end;
  logic          step;
  logic [PW-1:0] ptr_nxt;

  assign at_end   = (ptr == END_T) || (ptr == LAST);
  assign step     = adv && !load;
  assign wrap_now = step && at_end;

  always_comb begin
    ptr_nxt = ptr;
    if (load) begin
      if (load_val > AW'(N_REGS - 1)) ptr_nxt = '0;
      else                            ptr_nxt = load_val[PW-1:0];
    end else if (adv) begin
      if (at_end) ptr_nxt = '0;
      else        ptr_nxt = ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && ptr != END_T && ptr != LAST) |=> ptr == PW'($past(ptr) + 1'b1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(ptr));
  a_r3_time_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && ptr == END_T) |=> ptr == '0);
  a_r4_aux_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && ptr == LAST) |=> ptr == '0);
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val <= AW'(N_REGS - 1)) |=> ptr == $past(load_val[PW-1:0]));
  a_r5_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val > AW'(N_REGS - 1)) |=> ptr == '0);
endmodule

// File: rtl/rtc_snap.sv
module rtc_snap #(
  parameter int N_TIME = rtc_front_pkg::RTC_N_TIME,
  parameter int DW     = rtc_front_pkg::RTC_DW,
  localparam int SW    = N_TIME * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [SW-1:0] live_time,
  output logic [SW-1:0] snap
);
  for (genvar i = 0; i < N_TIME; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n || capture) snap[i*DW +: DW] <= live_time[i*DW +: DW];
    end
  end

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> snap == $past(live_time));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(snap));
endmodule

// File: rtl/rtc_wstage.sv
module rtc_wstage #(
  parameter int DW = rtc_front_pkg::RTC_DW,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_byte,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  input  logic [PW-1:0] ptr,
  output logic          commit_valid,
  output logic [PW-1:0] commit_addr,
  output logic [DW-1:0] commit_data,
  output logic          div_rst
);
  logic [DW-1:0] stage;
  logic [DW-1:0] stage_eff;

  assign stage_eff = wr_byte ? wr_data : stage;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage        <= '0;
      commit_valid <= 1'b0;
      commit_addr  <= '0;
      commit_data  <= '0;
      div_rst      <= 1'b0;
    end else begin
      if (wr_byte) stage <= wr_data;
      commit_valid <= wr_ack;
      div_rst      <= wr_ack && (ptr == '0);
      if (wr_ack) begin
        commit_addr <= ptr;
        commit_data <= stage_eff;
      end
    end
  end

  a_r9_div_only_secs: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst |-> (commit_valid && commit_addr == '0));
endmodule

// File: rtl/rtc_regfront.sv
module rtc_regfront #(
  parameter int DW     = rtc_front_pkg::RTC_DW,
  parameter int N_TIME = rtc_front_pkg::RTC_N_TIME,
  parameter int N_REGS = rtc_front_pkg::RTC_N_REGS,
  parameter int AW     = rtc_front_pkg::RTC_AW,
  localparam int PW    = $clog2(N_REGS),
  localparam int LW    = N_REGS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ptr_load,
  input  logic [AW-1:0] ptr_load_val,
  input  logic          rd_done,
  input  logic          wr_byte,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  input  logic [LW-1:0] live_regs,
  output logic [DW-1:0] rd_data,
  output logic          commit_valid,
  output logic [PW-1:0] commit_addr,
  output logic [DW-1:0] commit_data,
  output logic          div_rst
);
  logic [PW-1:0]          ptr;
  logic                   wrap_now;
  logic                   capture;
  logic [N_TIME*DW-1:0]   snap;
  logic [DW-1:0]          view_b [N_REGS];

  rtc_ptr #(.N_TIME(N_TIME), .N_REGS(N_REGS), .AW(AW), .PW(PW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ptr_load_val),
    .adv      (rd_done || wr_ack),
    .ptr      (ptr),
    .wrap_now (wrap_now)
  );

  assign capture = ev_start || ev_stop || wrap_now;

  rtc_snap #(.N_TIME(N_TIME), .DW(DW)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .live_time (live_regs[N_TIME*DW-1:0]),
    .snap      (snap)
  );

  rtc_wstage #(.DW(DW), .PW(PW)) u_wstage (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_byte      (wr_byte),
    .wr_data      (wr_data),
    .wr_ack       (wr_ack),
    .ptr          (ptr),
    .commit_valid (commit_valid),
    .commit_addr  (commit_addr),
    .commit_data  (commit_data),
    .div_rst      (div_rst)
  );

  // Read view: snapshot for timekeeping bytes, live for control and aux
  for (genvar i = 0; i < N_REGS; i++) begin : g_view
    if (i < N_TIME) begin : g_snap
      assign view_b[i] = snap[i*DW +: DW];
    end else begin : g_live
      assign view_b[i] = live_regs[i*DW +: DW];
    end
  end

  assign rd_data = view_b[ptr];

  a_r8_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> (commit_valid && commit_addr == $past(ptr)));
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ack |=> !commit_valid);
  a_r9_div_secs: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && ptr == '0) |=> div_rst);
  a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(N_REGS - 1));
endmodule

// File: tb/rtc_regfront_tb.sv
module rtc_regfront_tb;
  localparam int DW = 8;
  localparam int NR = 10;
  localparam int PW = 4;

  // op codes: 0 idle, 1 start, 2 stop, 3 load, 4 read byte, 5 write byte+ack, 6 load+read
  // vector: {op[3:0], arg[7:0], expected rd_data[7:0]}, live bytes = A0h+N
  localparam logic [19:0] VEC [14] = '{
    {4'd3, 8'h05, 8'hA5},  // R5 load 05
    {4'd4, 8'h00, 8'hA6},  // R2 step
    {4'd4, 8'h00, 8'hA7},  // R2 step to control, R7 live view
    {4'd4, 8'h00, 8'hA0},  // R3 07h -> 00h
    {4'd3, 8'h08, 8'hA8},  // R5 load aux
    {4'd4, 8'h00, 8'hA9},  // R2 08h -> 09h
    {4'd4, 8'h00, 8'hA0},  // R4 09h -> 00h
    {4'd3, 8'h09, 8'hA9},  // R5 load 09
    {4'd3, 8'h0C, 8'hA0},  // R5 clamp
    {4'd3, 8'h03, 8'hA3},  // R5
    {4'd5, 8'h55, 8'hA4},  // R2 step after write
    {4'd1, 8'h00, 8'hA4},  // start does not move pointer
    {4'd4, 8'h00, 8'hA5},  // R2
    {4'd3, 8'hFF, 8'hA0}   // R5 clamp
  };

  logic clk = 1'b0;
  logic rst_n;
  logic ev_start, ev_stop, ptr_load, rd_done, wr_byte, wr_ack;
  logic [7:0] ptr_load_val;
  logic [DW-1:0] wr_data;
  logic [NR*DW-1:0] live_regs;
  logic [DW-1:0] rd_data;
  logic commit_valid;
  logic [PW-1:0] commit_addr;
  logic [DW-1:0] commit_data;
  logic div_rst;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  rtc_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .rd_done(rd_done),
    .wr_byte(wr_byte), .wr_data(wr_data), .wr_ack(wr_ack), .live_regs(live_regs),
    .rd_data(rd_data), .commit_valid(commit_valid), .commit_addr(commit_addr),
    .commit_data(commit_data), .div_rst(div_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_live(input logic [7:0] base);
    for (int i = 0; i < NR; i++) live_regs[i*DW +: DW] = base + 8'(i);
  endtask

  task automatic clr();
    ev_start = 0; ev_stop = 0; ptr_load = 0; rd_done = 0;
    wr_byte = 0; wr_ack = 0;
  endtask

  // drive at a falling edge, return at the falling edge after the sampling edge
  task automatic op(input int kind, input logic [7:0] arg);
    @(negedge clk);
    clr();
    case (kind)
      1: ev_start = 1;
      2: ev_stop = 1;
      3: begin ptr_load = 1; ptr_load_val = arg; end
      4: rd_done = 1;
      5: begin
        wr_byte = 1; wr_data = arg;
        @(negedge clk);
        clr();
        wr_ack = 1;
      end
      6: begin ptr_load = 1; ptr_load_val = arg; rd_done = 1; end
      default: ;
    endcase
    @(negedge clk);
    clr();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    clr();
    ptr_load_val = 0;
    wr_data = 0;
    set_live(8'hA0);
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", 32'(rd_data), 32'hA0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_data after reset", 32'(rd_data), 32'hA0);
    chk("R1 commit_valid", 32'(commit_valid), 0);
    chk("R1 div_rst", 32'(div_rst), 0);

    for (int k = 0; k < 14; k++) begin
      op(int'(VEC[k][19:16]), VEC[k][15:8]);
      chk($sformatf("R2 R3 R4 R5 R7 vector %0d", k), 32'(rd_data), 32'(VEC[k][7:0]));
    end

    // R6: snapshot holds while live changes, refreshed on start
    op(3, 8'h00);
    set_live(8'hB0);
    op(0, 8'h00);
    chk("R6 hold while live moves", 32'(rd_data), 32'hA0);
    op(1, 8'h00);
    chk("R6 capture on start", 32'(rd_data), 32'hB0);
    set_live(8'hC0);
    op(3, 8'h06);
    chk("R6 snapshot byte 6 stale", 32'(rd_data), 32'hB6);
    op(4, 8'h00);
    chk("R7 control is live", 32'(rd_data), 32'hC7);
    op(4, 8'h00);
    chk("R6 capture on wrap to 00h", 32'(rd_data), 32'hC0);
    set_live(8'hD0);
    op(3, 8'h02);
    chk("R6 held before stop", 32'(rd_data), 32'hC2);
    op(2, 8'h00);
    chk("R6 capture on stop", 32'(rd_data), 32'hD2);

    // R8/R9: commit to seconds
    op(3, 8'h00);
    op(5, 8'h59);
    chk("R8 commit_valid", 32'(commit_valid), 1);
    chk("R8 commit_addr", 32'(commit_addr), 0);
    chk("R8 commit_data", 32'(commit_data), 32'h59);
    chk("R9 div_rst on seconds", 32'(div_rst), 1);
    op(0, 8'h00);
    chk("R8 single-cycle pulse", 32'(commit_valid), 0);
    chk("R9 div_rst drops", 32'(div_rst), 0);

    op(3, 8'h03);
    op(5, 8'h21);
    chk("R8 commit_addr 3", 32'(commit_addr), 3);
    chk("R8 commit_data 21", 32'(commit_data), 32'h21);
    chk("R9 no div_rst off seconds", 32'(div_rst), 0);
    chk("R2 step after write", 32'(rd_data), 32'hD4);

    // R5 priority of load over step
    op(6, 8'h06);
    chk("R5 load beats step", 32'(rd_data), 32'hD6);

    // R3/R6: write at control wraps and refreshes snapshot
    set_live(8'hE0);
    op(3, 8'h07);
    op(5, 8'h33);
    chk("R8 commit at control", 32'(commit_addr), 7);
    chk("R3 R6 write wrap refresh", 32'(rd_data), 32'hE0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule